// File: doc/BRIEF.md
# Accumulator Operand Addressing Unit

This block fetches operands and executes instructions for a one-address machine built around an accumulator. A decoded instruction arrives on a start strobe. It carries an operation code, a 3-bit addressing mode, a data/address field and a register selector, along with the current program counter. The unit works out the effective address from the mode and reads a synchronous, word-addressed memory zero, one or two times. It then either updates the accumulator or writes the accumulator back to the resolved target. The register file, the operand memory and the accumulator all sit inside the block.

Mode codes: 0 immediate, 1 direct, 2 indirect, 3 register, 4 register indirect, 5 displacement (field plus base register), 6 PC-relative (program counter plus field), 7 reserved. Effective addresses are the low ADDR_W bits of their sum and wrap modulo the memory size. A separate write port lets the surrounding logic load the general registers. Memory contents are set up through store instructions.

Top module: `acc_operand_unit`

## Requirements
- R1: After reset, and after reset is taken in the middle of an instruction, busy_o, done_o and err_o are low and acc_o is 0.
- R2: An immediate-mode operation (mode 0) uses the field itself as operand, makes no memory access, and raises done_o two clock edges after the edge that samples start_i.
- R3: A direct-mode operation (mode 1) reads memory at the field address once, and done_o for a load follows three edges after start.
- R4: An indirect-mode operation (mode 2) first reads the word at the field address and then uses that word as the operand address. A load takes four edges, so with word 30 = 50 and word 50 = 70, loading indirect 30 gives 70 while loading direct 30 gives 50.
- R5: Register mode (mode 3) uses the selected register as operand with no memory access and a two-edge latency. A store in this mode copies the accumulator into the selected register.
- R6: Register-indirect mode (mode 4) uses the selected register's low ADDR_W bits as the address. With register 1 = 40, storing after loading immediate 20 puts 20 in word 40.
- R7: Displacement mode (mode 5) addresses field + selected register, modulo 2^ADDR_W.
- R8: Relative mode (mode 6) addresses pc_i + field, modulo 2^ADDR_W.
- R9: Operation codes are 0 load, 1 store, 2 add, 3 subtract (acc minus operand) and 4 multiply. Results keep the low DATA_W bits.
- R10: A store in a memory mode writes the accumulator to the effective address and leaves the accumulator unchanged. Done follows two edges after start, or three in indirect mode.
- R11: Mode 7, operation codes 5 to 7, and store with immediate mode are illegal. They raise err_o together with done_o one edge after start and change neither the accumulator, the registers nor memory.
- R12: busy_o is high from the edge that samples start_i through the done cycle. done_o is a single-cycle pulse, and start_i is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the presented instruction (sampled when idle) |
| op_i | input | 3 | Operation code |
| mode_i | input | 3 | Addressing mode |
| field_i | input | DATA_W | Immediate value, address or displacement |
| rsel_i | input | RSEL_W | Register selector |
| pc_i | input | ADDR_W | Program counter for relative mode |
| rf_we_i | input | 1 | External register write enable |
| rf_waddr_i | input | RSEL_W | External register write index |
| rf_wdata_i | input | DATA_W | External register write data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal instruction, valid with done_o |
| acc_o | output | DATA_W | Accumulator |

## Verification
The assertions assume that start_i is only meaningful while the unit is idle, and that instruction fields are held steady for the sampling edge. The bench presents each instruction for exactly one sampling edge and waits for done_o before issuing the next, except in the one directed test that deliberately holds start_i high with changing fields while busy. The properties also assume register writes from outside do not race a register-mode store. The stimulus only uses the external register port before instructions run. Memory words are read only after a store has defined them, so no check depends on uninitialised storage.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_MUL   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        AM_IMM  = 3'd0,
        AM_DIR  = 3'd1,
        AM_IND  = 3'd2,
        AM_REG  = 3'd3,
        AM_RIND = 3'd4,
        AM_DISP = 3'd5,
        AM_REL  = 3'd6,
        AM_RSVD = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_IND,
        ST_OPR,
        ST_EXEC,
        ST_DONE
    } state_e;

    // Modes whose operand comes without touching memory.
    function automatic logic no_mem_mode(input logic [2:0] m);
        return (m == AM_IMM) || (m == AM_REG);
    endfunction

    function automatic logic is_illegal(input logic [2:0] o, input logic [2:0] m);
        logic bad_op;
        bad_op = (o > OP_MUL);
        return bad_op || (m == AM_RSVD) || ((m == AM_IMM) && (o == OP_STORE));
    endfunction

endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (we && (waddr == SEL_W'(g)))
                regs_q[g] <= wdata;
        end
    end

    assign rdata = regs_q[raddr];
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              re,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            words[addr] <= wdata;
        if (re)
            rdata <= words[addr];
    end
endmodule

// File: rtl/acc_ea_calc.sv
module acc_ea_calc
    import acc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] field_lo,
    input  logic [ADDR_W-1:0] reg_lo,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ea
);
    always_comb begin
        unique case (mode)
            AM_RIND: ea = reg_lo;
            AM_DISP: ea = field_lo + reg_lo;
            AM_REL:  ea = pc + field_lo;
            // Direct and indirect both start from the field; indirect
            // treats it as the pointer location.
            default: ea = field_lo;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [2*DATA_W-1:0] prod;

    assign prod = a * b;

    always_comb begin
        unique case (op)
            OP_LOAD: y = b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DATA_W-1:0];
            default: y = a;
        endcase
    end
endmodule

// File: rtl/acc_operand_unit.sv
module acc_operand_unit
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int NREG   = 4,
    localparam int RSEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] field_i,
    input  logic [RSEL_W-1:0] rsel_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              rf_we_i,
    input  logic [RSEL_W-1:0] rf_waddr_i,
    input  logic [DATA_W-1:0] rf_wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] acc_o
);
    state_e             state_q;
    logic [2:0]         op_q, mode_q;
    logic [ADDR_W-1:0]  ea_q;
    logic [DATA_W-1:0]  opnd_q;
    logic [RSEL_W-1:0]  rsel_q;
    logic               err_q;
    logic [DATA_W-1:0]  acc_q;

    logic [DATA_W-1:0]  rf_rdata;
    logic               rf_int_we, rf_we;
    logic [RSEL_W-1:0]  rf_waddr;
    logic [DATA_W-1:0]  rf_wdata;

    logic [ADDR_W-1:0]  ea_c;
    logic [ADDR_W-1:0]  mem_addr;
    logic               mem_re, mem_we;
    logic [DATA_W-1:0]  mem_rdata;
    logic [DATA_W-1:0]  operand;
    logic [DATA_W-1:0]  alu_y;
    logic               is_store;
    logic               illegal_c;

    // Register file: internal register-mode store has priority.
    assign rf_int_we = (state_q == ST_EXEC) && (op_q == OP_STORE);
    assign rf_we     = rf_int_we || rf_we_i;
    assign rf_waddr  = rf_int_we ? rsel_q : rf_waddr_i;
    assign rf_wdata  = rf_int_we ? acc_q  : rf_wdata_i;

    acc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rsel_i),
        .rdata (rf_rdata)
    );

    acc_ea_calc #(.ADDR_W(ADDR_W)) u_ea (
        .mode     (mode_i),
        .field_lo (field_i[ADDR_W-1:0]),
        .reg_lo   (rf_rdata[ADDR_W-1:0]),
        .pc       (pc_i),
        .ea       (ea_c)
    );

    assign illegal_c = is_illegal(op_i, mode_i);
    assign is_store  = (op_q == OP_STORE);

    // In the second indirect step the pointer word addresses memory directly.
    assign mem_addr = (state_q == ST_IND) ? mem_rdata[ADDR_W-1:0] : ea_q;
    assign mem_re   = (state_q == ST_PTR) ||
                      (((state_q == ST_OPR) || (state_q == ST_IND)) && !is_store);
    assign mem_we   = ((state_q == ST_OPR) || (state_q == ST_IND)) && is_store;

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .addr  (mem_addr),
        .re    (mem_re),
        .we    (mem_we),
        .wdata (acc_q),
        .rdata (mem_rdata)
    );

    assign operand = no_mem_mode(mode_q) ? opnd_q : mem_rdata;

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op (op_q),
        .a  (acc_q),
        .b  (operand),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LOAD;
            mode_q  <= AM_IMM;
            ea_q    <= '0;
            opnd_q  <= '0;
            rsel_q  <= '0;
            err_q   <= 1'b0;
            acc_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q   <= op_i;
                        mode_q <= mode_i;
                        rsel_q <= rsel_i;
                        ea_q   <= ea_c;
                        opnd_q <= (mode_i == AM_REG) ? rf_rdata : field_i;
                        err_q  <= illegal_c;
                        if (illegal_c)
                            state_q <= ST_DONE;
                        else if (no_mem_mode(mode_i))
                            state_q <= ST_EXEC;
                        else if (mode_i == AM_IND)
                            state_q <= ST_PTR;
                        else
                            state_q <= ST_OPR;
                    end
                end
                ST_PTR:  state_q <= ST_IND;
                ST_IND,
                ST_OPR:  state_q <= is_store ? ST_DONE : ST_EXEC;
                ST_EXEC: begin
                    if (!is_store)
                        acc_q <= alu_y;
                    state_q <= ST_DONE;
                end
                ST_DONE: begin
                    err_q   <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);
    assign err_o  = (state_q == ST_DONE) && err_q;
    assign acc_o  = acc_q;

endmodule

// File: rtl/acc_operand_chk.sv
module acc_operand_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] acc,
    input logic              mem_re,
    input logic              mem_we,
    input logic [2:0]        mode_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !err && acc == '0));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R11
    err_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> $stable(acc));

    // R2
    no_mem_access_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (mode_q == 3'd0 || mode_q == 3'd3)) |-> (!mem_re && !mem_we));

    // R10
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(acc));

endmodule

bind acc_operand_unit acc_operand_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy_o),
    .done   (done_o),
    .err    (err_o),
    .acc    (acc_o),
    .mem_re (mem_re),
    .mem_we (mem_we),
    .mode_q (mode_q)
);

// File: tb/acc_operand_unit_bench.sv
module acc_operand_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int NREG   = 4;
    localparam int RSEL_W = 2;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  mode;
        logic [15:0] field;
        logic [1:0]  rsel;
        logic [7:0]  pc;
        logic [15:0] exp_acc;
        logic [2:0]  lat;
        logic        err;
    } vec_t;

    localparam int NV = 46;
    // op: 0 ld 1 st 2 add 3 sub 4 mul; mode: 0 imm 1 dir 2 ind 3 reg 4 rind 5 disp 6 rel 7 rsvd
    localparam vec_t TBL [NV] = '{
        '{3'd0, 3'd0, 16'd40,  2'd0, 8'd0,   16'd40,    3'd2, 1'b0}, // R2
        '{3'd1, 3'd1, 16'd20,  2'd0, 8'd0,   16'd40,    3'd2, 1'b0}, // R10
        '{3'd0, 3'd0, 16'd60,  2'd0, 8'd0,   16'd60,    3'd2, 1'b0},
        '{3'd1, 3'd1, 16'd40,  2'd0, 8'd0,   16'd60,    3'd2, 1'b0},
        '{3'd0, 3'd0, 16'd50,  2'd0, 8'd0,   16'd50,    3'd2, 1'b0},
        '{3'd1, 3'd1, 16'd30,  2'd0, 8'd0,   16'd50,    3'd2, 1'b0},
        '{3'd0, 3'd0, 16'd70,  2'd0, 8'd0,   16'd70,    3'd2, 1'b0},
        '{3'd1, 3'd1, 16'd50,  2'd0, 8'd0,   16'd70,    3'd2, 1'b0},
        '{3'd0, 3'd1, 16'd30,  2'd0, 8'd0,   16'd50,    3'd3, 1'b0}, // R3
        '{3'd0, 3'd2, 16'd30,  2'd0, 8'd0,   16'd70,    3'd4, 1'b0}, // R4
        '{3'd0, 3'd2, 16'd20,  2'd0, 8'd0,   16'd60,    3'd4, 1'b0}, // R4
        '{3'd0, 3'd0, 16'd20,  2'd0, 8'd0,   16'd20,    3'd2, 1'b0},
        '{3'd1, 3'd4, 16'd0,   2'd1, 8'd0,   16'd20,    3'd2, 1'b0}, // R6 store
        '{3'd0, 3'd1, 16'd40,  2'd0, 8'd0,   16'd20,    3'd3, 1'b0}, // R6
        '{3'd0, 3'd4, 16'd0,   2'd1, 8'd0,   16'd20,    3'd3, 1'b0}, // R6 load
        '{3'd0, 3'd1, 16'd20,  2'd0, 8'd0,   16'd40,    3'd3, 1'b0},
        '{3'd2, 3'd3, 16'd0,   2'd2, 8'd0,   16'd100,   3'd2, 1'b0}, // R5
        '{3'd0, 3'd1, 16'd30,  2'd0, 8'd0,   16'd50,    3'd3, 1'b0},
        '{3'd3, 3'd3, 16'd0,   2'd1, 8'd0,   16'd10,    3'd2, 1'b0}, // R9 sub
        '{3'd0, 3'd2, 16'd30,  2'd0, 8'd0,   16'd70,    3'd4, 1'b0},
        '{3'd4, 3'd0, 16'd2,   2'd0, 8'd0,   16'd140,   3'd2, 1'b0}, // R9 mul
        '{3'd0, 3'd1, 16'd50,  2'd0, 8'd0,   16'd70,    3'd3, 1'b0},
        '{3'd3, 3'd2, 16'd40,  2'd0, 8'd0,   16'd30,    3'd4, 1'b0}, // R9 sub indirect
        '{3'd0, 3'd5, 16'd20,  2'd3, 8'd0,   16'd50,    3'd3, 1'b0}, // R7
        '{3'd0, 3'd6, 16'd10,  2'd0, 8'd40,  16'd70,    3'd3, 1'b0}, // R8
        '{3'd0, 3'd0, 16'd99,  2'd0, 8'd0,   16'd99,    3'd2, 1'b0},
        '{3'd1, 3'd5, 16'd250, 2'd1, 8'd0,   16'd99,    3'd2, 1'b0}, // R7 wraps to 34
        '{3'd0, 3'd0, 16'd0,   2'd0, 8'd0,   16'd0,     3'd2, 1'b0},
        '{3'd2, 3'd1, 16'd34,  2'd0, 8'd0,   16'd99,    3'd3, 1'b0}, // R7 add
        '{3'd0, 3'd0, 16'd3,   2'd0, 8'd0,   16'd3,     3'd2, 1'b0},
        '{3'd3, 3'd0, 16'd5,   2'd0, 8'd0,   16'd65534, 3'd2, 1'b0}, // R9 wrap
        '{3'd1, 3'd0, 16'd20,  2'd0, 8'd0,   16'd65534, 3'd1, 1'b1}, // R11 imm store
        '{3'd0, 3'd1, 16'd20,  2'd0, 8'd0,   16'd40,    3'd3, 1'b0}, // R11 memory kept
        '{3'd0, 3'd7, 16'd20,  2'd0, 8'd0,   16'd40,    3'd1, 1'b1}, // R11 mode 7
        '{3'd5, 3'd1, 16'd20,  2'd0, 8'd0,   16'd40,    3'd1, 1'b1}, // R11 op 5
        '{3'd0, 3'd0, 16'd123, 2'd0, 8'd0,   16'd123,   3'd2, 1'b0},
        '{3'd1, 3'd3, 16'd0,   2'd2, 8'd0,   16'd123,   3'd2, 1'b0}, // R5 reg store
        '{3'd0, 3'd0, 16'd0,   2'd0, 8'd0,   16'd0,     3'd2, 1'b0},
        '{3'd2, 3'd3, 16'd0,   2'd2, 8'd0,   16'd123,   3'd2, 1'b0}, // R5
        '{3'd0, 3'd0, 16'd77,  2'd0, 8'd0,   16'd77,    3'd2, 1'b0},
        '{3'd1, 3'd2, 16'd30,  2'd0, 8'd0,   16'd77,    3'd3, 1'b0}, // R10 indirect store
        '{3'd0, 3'd1, 16'd50,  2'd0, 8'd0,   16'd77,    3'd3, 1'b0}, // R10
        '{3'd1, 3'd6, 16'd5,   2'd0, 8'd100, 16'd77,    3'd2, 1'b0}, // R8 store
        '{3'd0, 3'd1, 16'd105, 2'd0, 8'd0,   16'd77,    3'd3, 1'b0}, // R8
        '{3'd0, 3'd0, 16'd300, 2'd0, 8'd0,   16'd300,   3'd2, 1'b0},
        '{3'd4, 3'd0, 16'd300, 2'd0, 8'd0,   16'd24464, 3'd2, 1'b0}  // R9 mul wrap
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [2:0]        op_i = '0, mode_i = '0;
    logic [DATA_W-1:0] field_i = '0;
    logic [RSEL_W-1:0] rsel_i = '0;
    logic [ADDR_W-1:0] pc_i = '0;
    logic              rf_we_i = 1'b0;
    logic [RSEL_W-1:0] rf_waddr_i = '0;
    logic [DATA_W-1:0] rf_wdata_i = '0;
    logic              busy_o, done_o, err_o;
    logic [DATA_W-1:0] acc_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_operand_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_acc_operand_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
        .field_i(field_i), .rsel_i(rsel_i), .pc_i(pc_i), .rf_we_i(rf_we_i),
        .rf_waddr_i(rf_waddr_i), .rf_wdata_i(rf_wdata_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .acc_o(acc_o)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_reg(input int idx, input int val);
        @(negedge clk);
        rf_we_i = 1'b1; rf_waddr_i = RSEL_W'(idx); rf_wdata_i = DATA_W'(val);
        @(negedge clk);
        rf_we_i = 1'b0;
    endtask

    // Issue one instruction; returns edges from the sampling edge until done.
    task automatic issue(input vec_t v, output int lat, output logic err_seen);
        @(negedge clk);
        op_i = v.op; mode_i = v.mode; field_i = v.field; rsel_i = v.rsel; pc_i = v.pc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        err_seen = err_o;
    endtask

    initial begin
        int lat;
        logic e;
        vec_t v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !err_o, "R1 reset flags", int'(busy_o), 0);
        check(acc_o == 0, "R1 reset acc", int'(acc_o), 0);
        rst = 1'b0;
        set_reg(1, 40);
        set_reg(2, 60);
        set_reg(3, 10);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i], lat, e);
            check(lat == int'(TBL[i].lat), $sformatf("row %0d latency (R2 R3 R4 R10 R11)", i),
                  lat, int'(TBL[i].lat));
            check(e == TBL[i].err, $sformatf("row %0d err (R11)", i), int'(e), int'(TBL[i].err));
            check(acc_o == TBL[i].exp_acc, $sformatf("row %0d acc (R9)", i),
                  int'(acc_o), int'(TBL[i].exp_acc));
        end

        // R12: done is one cycle, then idle
        @(negedge clk);
        check(!done_o && !busy_o, "R12 done single pulse", int'(done_o), 0);

        // R12: start held high with changing fields while busy is ignored
        @(negedge clk);
        op_i = 3'd0; mode_i = 3'd2; field_i = 16'd30; start_i = 1'b1; // indirect 30 -> 50 -> 77
        @(negedge clk);
        check(busy_o, "R12 busy after start", int'(busy_o), 1);
        op_i = 3'd0; mode_i = 3'd0; field_i = 16'd9;
        @(negedge clk);
        check(busy_o, "R12 busy holds", int'(busy_o), 1);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(acc_o == 16'd77, "R12 start ignored while busy", int'(acc_o), 77);

        // R1: reset in the middle of an instruction
        v = '{3'd0, 3'd2, 16'd30, 2'd0, 8'd0, 16'd0, 3'd0, 1'b0};
        @(negedge clk);
        op_i = v.op; mode_i = v.mode; field_i = v.field; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !err_o, "R1 mid reset flags", int'(busy_o), 0);
        check(acc_o == 0, "R1 mid reset acc", int'(acc_o), 0);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule